// File: doc/BRIEF.md
# Synchronisation Code Generator

This block produces a 256-chip synchronisation code as a serial stream of sign bits, one chip for each cycle in which the chip enable is high. It makes either the primary code or one of sixteen secondary codes. The real and imaginary parts of every chip are equal, so a single sign bit describes the complex chip completely.

The primary code takes a fixed 16-chip base sequence and repeats it sixteen times. Each repetition is multiplied by one sign from a fixed 16-entry outer pattern. A secondary code uses a second base sequence, derived from the first, with its own outer pattern. It then multiplies each chip by one row of a 256×256 Sylvester Hadamard matrix, selected by the secondary index k. Chips are computed on the fly from the chip counter, so the block holds no 256-entry table.

A run starts on a start strobe while the block is idle. Chips then leave on each chip enable until the last chip, which is marked with a done flag.

Top module: `sync_code_gen`

## Requirements
- R1: After reset, `chip_out`, `chip_valid`, `chip_done` and `idx_err` are all 0.
- R2: A `start` pulse while idle begins a run. From then on, every cycle with `chip_en` high produces one chip: in the next cycle `chip_valid` is 1 and `chip_out` holds that chip. A run has exactly 256 chips.
- R3: With `sel_ssc`=0 the chips form the primary code. Chip i (0-based, first sent first) has the value a[i mod 16]·p[i div 16], where a = 1,1,1,1,1,1,−1,−1,1,−1,1,−1,1,−1,−1,1 and p = +,+,+,−,−,+,−,−,+,+,+,−,+,−,+,+. `chip_out`=1 encodes −1 and 0 encodes +1.
- R4: With `sel_ssc`=1 and `ssc_idx`=k in 1..16, chip i has the value h(16(k−1), i)·b[i mod 16]·s[i div 16]. Here b is a with its 0-based chips 8 to 14 negated. s = +,+,+,−,+,+,−,−,+,−,+,−,−,−,−,−. h(m, i) is entry (m, i) of the 256×256 Sylvester Hadamard matrix whose row 0 is all ones. The same sign encoding as R3 applies.
- R5: `chip_done` is 1 in the same cycle as the valid flag of chip 255, and only then. After that chip the block is idle, and further `chip_en` cycles produce no `chip_valid`.
- R6: A `start` with `sel_ssc`=1 and `ssc_idx` outside 1..16 raises `idx_err` for exactly one cycle, in the cycle after the start. It starts no run, so no chip follows.
- R7: A `start` that arrives during a run is ignored: the running code continues unchanged to its last chip.
- R8: A cycle with `chip_en` low does not advance the code and gives `chip_valid`=0. The next enabled cycle continues with the following chip.
- R9: With `sel_ssc`=0 the value of `ssc_idx` has no effect: even `ssc_idx`=0 gives the primary code and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a code when idle |
| sel_ssc | input | 1 | 0: primary code, 1: secondary code |
| ssc_idx | input | 5 | Secondary code number k, valid 1..16 |
| chip_en | input | 1 | Advance one chip |
| chip_out | output | 1 | Chip sign, 1 means −1 |
| chip_valid | output | 1 | `chip_out` holds a new chip |
| chip_done | output | 1 | Last chip of the code |
| idx_err | output | 1 | Rejected secondary index |

## Verification
The block has a single fixed configuration, and it is small enough for the bench to cover all of it. The bench runs the primary code and all sixteen secondary codes over their full 256 chips. It compares every chip with a value it builds from the base sequences, the outer patterns and a 16×16 Sylvester matrix that it grows by doubling. Several runs insert idle enable cycles or a stray start in the middle of the code. The bench also tries every rejected index from 0 to 31.

// File: rtl/sync_code_gen.sv
module sync_code_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sel_ssc,
  input  logic [4:0] ssc_idx,
  input  logic       chip_en,
  output logic       chip_out,
  output logic       chip_valid,
  output logic       chip_done,
  output logic       idx_err
);

  localparam logic [15:0] BASE_A_NEG = 16'h6AC0;
  localparam logic [15:0] BASE_B_NEG = 16'h15C0;
  localparam logic [15:0] OUT_P_NEG  = 16'h28D8;
  localparam logic [15:0] OUT_S_NEG  = 16'hFAC8;
  localparam int          LEN        = 256;

  logic       busy;
  logic       mode_ssc;
  logic [3:0] row;
  logic [7:0] cnt;
  logic       idx_ok;
  logic       had_neg;
  logic       chip_nxt;

  assign idx_ok  = (ssc_idx >= 5'd1) && (ssc_idx <= 5'd16);
  assign had_neg = ^(row & cnt[7:4]);
  assign chip_nxt = mode_ssc ? (BASE_B_NEG[cnt[3:0]] ^ OUT_S_NEG[cnt[7:4]] ^ had_neg)
                             : (BASE_A_NEG[cnt[3:0]] ^ OUT_P_NEG[cnt[7:4]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      mode_ssc   <= 1'b0;
      row        <= '0;
      cnt        <= '0;
      chip_out   <= 1'b0;
      chip_valid <= 1'b0;
      chip_done  <= 1'b0;
      idx_err    <= 1'b0;
    end else begin
      chip_valid <= 1'b0;
      chip_done  <= 1'b0;
      idx_err    <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (sel_ssc && !idx_ok) begin
            idx_err <= 1'b1;
          end else begin
            busy     <= 1'b1;
            mode_ssc <= sel_ssc;
            row      <= ssc_idx[3:0] - 4'd1;
            cnt      <= '0;
          end
        end
      end else if (chip_en) begin
        chip_valid <= 1'b1;
        chip_out   <= chip_nxt;
        chip_done  <= (cnt == 8'(LEN - 1));
        cnt        <= cnt + 8'd1;
        if (cnt == 8'(LEN - 1)) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sync_code_gen_chk.sv
module sync_code_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       sel_ssc,
  input logic [4:0] ssc_idx,
  input logic       chip_en,
  input logic       chip_out,
  input logic       chip_valid,
  input logic       chip_done,
  input logic       idx_err
);

  p_valid_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |-> $past(chip_en));

  p_done_with_chip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chip_done |-> chip_valid);

  p_err_from_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> ($past(start) && $past(sel_ssc)));

  p_err_no_chip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> !chip_valid);

  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> !idx_err);

  p_err_not_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> !chip_valid);

endmodule

bind sync_code_gen sync_code_gen_chk u_chk (.*);

// File: tb/test_sync_code_gen.sv
`timescale 1ns/1ps
module test_sync_code_gen;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic       sel_ssc = 0;
  logic [4:0] ssc_idx = 0;
  logic       chip_en = 0;
  logic       chip_out, chip_valid, chip_done, idx_err;

  int total = 0;
  int bad = 0;
  int a_seq [16] = '{1,1,1,1,1,1,-1,-1,1,-1,1,-1,1,-1,-1,1};
  int p_out [16] = '{1,1,1,-1,-1,1,-1,-1,1,1,1,-1,1,-1,1,1};
  int s_out [16] = '{1,1,1,-1,1,1,-1,-1,1,-1,1,-1,-1,-1,-1,-1};
  int b_seq [16];
  int had [16][16];

  sync_code_gen i_sync_code_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_ssc(sel_ssc), .ssc_idx(ssc_idx),
    .chip_en(chip_en), .chip_out(chip_out), .chip_valid(chip_valid),
    .chip_done(chip_done), .idx_err(idx_err));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_bit(input bit ssc, input int k, input int i);
    int v;
    if (ssc) v = had[k-1][i/16] * b_seq[i%16] * s_out[i/16];
    else     v = a_seq[i%16] * p_out[i/16];
    return (v < 0) ? 1 : 0;
  endfunction

  task automatic run_code(input bit ssc, input int k, input bit gaps, input bit stray);
    string req;
    int mism;
    req  = ssc ? "R4" : "R3";
    mism = 0;
    @(negedge clk);
    start = 1; sel_ssc = ssc; ssc_idx = 5'(k);
    @(negedge clk);
    start = 0;
    check(ssc ? "R6" : "R9", idx_err, 0, "no error on accepted start");
    for (int i = 0; i < 256; i++) begin
      if (gaps && (i % 3 == 1)) begin
        chip_en = 0;
        @(negedge clk);
        check("R8", chip_valid, 0, "valid during idle enable");
      end
      chip_en = 1;
      if (stray && i == 100) begin
        start = 1; sel_ssc = ~ssc; ssc_idx = 5'd3;
      end
      @(negedge clk);
      chip_en = 0; start = 0;
      if (chip_valid !== 1'b1) begin
        check("R2", chip_valid, 1, $sformatf("valid chip %0d", i));
      end
      if (int'(chip_out) != exp_bit(ssc, k, i)) begin
        mism++;
        if (mism < 4)
          check(stray ? "R7" : req, chip_out, exp_bit(ssc, k, i), $sformatf("k=%0d chip %0d", k, i));
      end
      if (int'(chip_done) != ((i == 255) ? 1 : 0))
        check("R5", chip_done, (i == 255) ? 1 : 0, $sformatf("done at chip %0d", i));
    end
    check(stray ? "R7" : req, mism, 0, $sformatf("mismatching chips k=%0d sel=%0d", k, ssc));
    check("R5", chip_done, 1, "done on last chip");
    chip_en = 1;
    @(negedge clk);
    chip_en = 0;
    check("R5", chip_valid, 0, "no chip after end of run");
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 16; j++) b_seq[j] = (j >= 8 && j <= 14) ? -a_seq[j] : a_seq[j];
    had[0][0] = 1;
    for (int s = 1; s < 16; s = s * 2)
      for (int r = 0; r < s; r++)
        for (int c = 0; c < s; c++) begin
          had[r][c+s]   = had[r][c];
          had[r+s][c]   = had[r][c];
          had[r+s][c+s] = -had[r][c];
        end

    repeat (3) @(negedge clk);
    check("R1", chip_out, 0, "chip_out after reset");
    check("R1", chip_valid, 0, "chip_valid after reset");
    check("R1", chip_done, 0, "chip_done after reset");
    check("R1", idx_err, 0, "idx_err after reset");
    rst_n = 1;
    @(negedge clk);

    run_code(1'b0, 0, 1'b0, 1'b0);
    for (int k = 1; k <= 16; k++) run_code(1'b1, k, (k % 4 == 0), 1'b0);
    run_code(1'b0, 7, 1'b1, 1'b1);
    run_code(1'b1, 16, 1'b0, 1'b1);

    for (int v = 0; v < 32; v++) begin
      if (v >= 1 && v <= 16) continue;
      @(negedge clk);
      start = 1; sel_ssc = 1; ssc_idx = 5'(v);
      @(negedge clk);
      start = 0;
      check("R6", idx_err, 1, $sformatf("error for index %0d", v));
      chip_en = 1;
      @(negedge clk);
      chip_en = 0;
      check("R6", idx_err, 0, $sformatf("error is one cycle, index %0d", v));
      check("R6", chip_valid, 0, $sformatf("no chip after index %0d", v));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule